// File: doc/BRIEF.md
# Clock Generator Configuration Target on a Two-Wire Serial Bus

This block is the serial configuration port of a clock generator. It listens to a two-wire SMBus/I2C bus as a target only, answers to one fixed 7-bit address, and holds a small bank of byte-wide registers. The system clock is much faster than the bus, so SCL and SDA are first passed through synchronizers. Bus edges, start conditions and stop conditions are then found by comparing each sample with the one before it. SDA is never driven high. The block only asks the pad to pull the line low through `sda_oe_o`.

Both transfer directions carry a byte count. A write sends the register offset, a non-zero count and then that many data bytes. These bytes go to consecutive registers. A read sends the offset, then a repeated start and the read address. The target first returns a count byte and then the register contents from the offset onward, until the controller answers a byte with NACK.

Register 0 drives the output-enable logic. It has two per-output enables, a selector between pin control and register control, and a global enable. Its middle four bits are reserved. The whole bank is also presented as a flat vector for the rest of the chip.

Top module: `clkcfg_smbus_target`

## Requirements
- R1: The target acknowledges only the address bytes D2h (write) and D3h (read), which correspond to the 7-bit address 1101001. After any other address it releases SDA and acknowledges nothing until the next start condition.
- R2: In a block write, the offset, a non-zero count N and the first N data bytes are each acknowledged. Data byte k is stored in register offset+k.
- R3: A write count byte of 00h is answered with NACK. No data byte that follows it in the same transfer is acknowledged or stored.
- R4: In a write, any data byte beyond the count N is answered with NACK and is not stored.
- R5: In a block read, the target first returns a count equal to NUM_REGS minus the offset, then register contents starting at the offset. It continues while the controller acknowledges, and after the NACK it releases SDA.
- R6: After reset, register 0 reads A1h and every other register reads 00h.
- R7: Bits 4 to 1 of register 0 always read 0, and writes to them are ignored. Bits 7, 6, 5 and 0 store the written value.
- R8: When register 0 bit 6 is 0 (pin control), `oe0_o` follows `hw_oe0_i`, `oe1_o` follows `hw_oe1_i`, and `all_en_o` is 1.
- R9: When register 0 bit 6 is 1 (register control), `all_en_o` equals bit 5, `oe0_o` equals bit 7 AND bit 5, and `oe1_o` equals bit 0 AND bit 5.
- R10: When the offset is NUM_REGS or higher, the read count byte is 00h and the data bytes read 00h. Data bytes written there are acknowledged up to the count but change no register.
- R11: A stop condition seen at any point, including in the middle of a byte, returns the target to idle with SDA released. Bytes that are clocked afterwards without a new start are neither acknowledged nor stored.
- R12: SDA is pulled low only during an acknowledge bit or a bit of a byte being read. It is released from the first cycle after a stop condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock as seen at the pad |
| sda_i | input | 1 | Bus data as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| hw_oe0_i | input | 1 | Pin-controlled enable for output 0 |
| hw_oe1_i | input | 1 | Pin-controlled enable for output 1 |
| oe0_o | output | 1 | Effective enable for output 0 |
| oe1_o | output | 1 | Effective enable for output 1 |
| all_en_o | output | 1 | Effective global output enable |
| cfg_o | output | NUM_REGS*8 | Register bank, register i in bits i*8+7 down to i*8 |

## Verification
The bench builds the block with NUM_REGS = 4 and SYNC_STAGES = 2. A four-register bank is small enough that every offset inside the bank can be read through to its end. It also puts offsets past the end, and a write that starts inside the bank and runs past it, within a few bytes. SCL is driven with a quarter period of ten system clocks, which leaves the synchronizer delay well inside each bus phase. The model of the enable outputs and the bank is compared with the design on every clock.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RX,
        S_ACK,
        S_TX,
        S_MACK,
        S_SKIP
    } bus_st_e;

    typedef enum logic [1:0] {
        F_ADDR,
        F_OFFS,
        F_CNT,
        F_DATA
    } field_e;

    localparam logic [7:0] REG0_RST   = 8'hA1;
    localparam logic [7:0] REG0_WMASK = 8'hE1;
    localparam int         BIT_OE0    = 7;
    localparam int         BIT_SWCTL  = 6;
    localparam int         BIT_ALLEN  = 5;
    localparam int         BIT_OE1    = 0;

endpackage

// File: rtl/clkcfg_line_sync.sv
module clkcfg_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    typedef struct packed {
        logic [STAGES-1:0] scl;
        logic [STAGES-1:0] sda;
        logic              scl_p;
        logic              sda_p;
    } sync_t;

    sync_t q, d;
    logic  scl_s;

    assign scl_s = q.scl[STAGES-1];
    assign sda_s = q.sda[STAGES-1];

    always_comb begin
        d       = q;
        d.scl   = {q.scl[STAGES-2:0], scl_i};
        d.sda   = {q.sda[STAGES-2:0], sda_i};
        d.scl_p = scl_s;
        d.sda_p = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign scl_rise  = scl_s & ~q.scl_p;
    assign scl_fall  = ~scl_s & q.scl_p;
    assign start_det = scl_s & q.scl_p & ~sda_s & q.sda_p;
    assign stop_det  = scl_s & q.scl_p & sda_s & ~q.sda_p;

endmodule

// File: rtl/clkcfg_bus_engine.sv
module clkcfg_bus_engine
    import clkcfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b1101001,
    parameter int         NUM_REGS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic [7:0] rd_data,
    output logic [7:0] rd_addr,
    output logic       wr_en,
    output logic [7:0] wr_addr,
    output logic [7:0] wr_data,
    output logic       sda_oe
);

    localparam logic [7:0] NREG8 = 8'(NUM_REGS);

    typedef struct packed {
        bus_st_e    st;
        field_e     fld;
        logic [7:0] sh;
        logic [3:0] cnt;
        logic [7:0] offs;
        logic [7:0] ptr;
        logic [7:0] rem;
        logic       to_tx;
        logic       sda_oe;
        logic       we;
        logic [7:0] waddr;
        logic [7:0] wdata;
    } eng_t;

    eng_t       q, d;
    logic [7:0] avail;

    assign avail = (q.offs < NREG8) ? (NREG8 - q.offs) : 8'd0;

    always_comb begin
        d    = q;
        d.we = 1'b0;
        if (stop_det) begin
            d.st     = S_IDLE;
            d.sda_oe = 1'b0;
        end else if (start_det) begin
            d.st     = S_RX;
            d.fld    = F_ADDR;
            d.cnt    = 4'd0;
            d.sda_oe = 1'b0;
        end else begin
            unique case (q.st)
                S_RX: begin
                    if (scl_rise && q.cnt != 4'd8) begin
                        d.sh  = {q.sh[6:0], sda_s};
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall && q.cnt == 4'd8) begin
                        d.cnt = 4'd0;
                        d.st  = S_SKIP;
                        unique case (q.fld)
                            F_ADDR: begin
                                if (q.sh[7:1] == DEV_ADDR) begin
                                    d.st     = S_ACK;
                                    d.sda_oe = 1'b1;
                                    d.to_tx  = q.sh[0];
                                    if (q.sh[0]) begin
                                        d.sh  = avail;
                                        d.ptr = q.offs;
                                    end else begin
                                        d.fld = F_OFFS;
                                    end
                                end
                            end
                            F_OFFS: begin
                                d.offs   = q.sh;
                                d.ptr    = q.sh;
                                d.fld    = F_CNT;
                                d.st     = S_ACK;
                                d.sda_oe = 1'b1;
                            end
                            F_CNT: begin
                                if (q.sh != 8'd0) begin
                                    d.rem    = q.sh;
                                    d.fld    = F_DATA;
                                    d.st     = S_ACK;
                                    d.sda_oe = 1'b1;
                                end
                            end
                            F_DATA: begin
                                if (q.rem != 8'd0) begin
                                    d.we     = 1'b1;
                                    d.waddr  = q.ptr;
                                    d.wdata  = q.sh;
                                    d.ptr    = q.ptr + 8'd1;
                                    d.rem    = q.rem - 8'd1;
                                    d.st     = S_ACK;
                                    d.sda_oe = 1'b1;
                                end
                            end
                            default: ;
                        endcase
                    end
                end
                S_ACK: begin
                    if (scl_fall) begin
                        d.cnt = 4'd0;
                        if (q.to_tx) begin
                            d.st     = S_TX;
                            d.sda_oe = ~q.sh[7];
                        end else begin
                            d.st     = S_RX;
                            d.sda_oe = 1'b0;
                        end
                    end
                end
                S_TX: begin
                    if (scl_fall) begin
                        if (q.cnt == 4'd7) begin
                            d.st     = S_MACK;
                            d.sda_oe = 1'b0;
                        end else begin
                            d.sh     = {q.sh[6:0], 1'b0};
                            d.sda_oe = ~q.sh[6];
                            d.cnt    = q.cnt + 4'd1;
                        end
                    end
                end
                S_MACK: begin
                    if (scl_rise && sda_s) begin
                        d.st = S_SKIP;
                    end else if (scl_fall) begin
                        d.st     = S_TX;
                        d.sh     = rd_data;
                        d.ptr    = q.ptr + 8'd1;
                        d.cnt    = 4'd0;
                        d.sda_oe = ~rd_data[7];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= S_IDLE;
            q.fld   <= F_ADDR;
        end else begin
            q <= d;
        end
    end

    assign rd_addr = q.ptr;
    assign wr_en   = q.we;
    assign wr_addr = q.waddr;
    assign wr_data = q.wdata;
    assign sda_oe  = q.sda_oe;

    // R11
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!sda_oe && q.st == S_IDLE));

    // R3
    zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_RX && q.fld == F_CNT && scl_fall && q.cnt == 4'd8 &&
         q.sh == 8'd0 && !start_det && !stop_det) |=> (!sda_oe && q.st == S_SKIP));

    // R4
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($past(q.rem) != 8'd0));

    // R1
    addr_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_ACK && $past(q.st) == S_RX && $past(q.fld) == F_ADDR)
        |-> ($past(q.sh[7:1]) == DEV_ADDR));

endmodule

// File: rtl/clkcfg_reg_bank.sv
module clkcfg_reg_bank
    import clkcfg_pkg::*;
#(
    parameter int NUM_REGS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [7:0]            wr_addr,
    input  logic [7:0]            wr_data,
    input  logic [7:0]            rd_addr,
    output logic [7:0]            rd_data,
    input  logic                  hw_oe0_i,
    input  logic                  hw_oe1_i,
    output logic                  oe0_o,
    output logic                  oe1_o,
    output logic                  all_en_o,
    output logic [NUM_REGS*8-1:0] bank_o
);

    localparam int         BW    = NUM_REGS * 8;
    localparam logic [8:0] NREG9 = 9'(NUM_REGS);
    localparam logic [7:0] LAST  = 8'(NUM_REGS - 1);

    logic [BW-1:0] bank_q, bank_d, rst_vec;
    logic          sw_ctl;

    always_comb begin
        rst_vec      = '0;
        rst_vec[7:0] = REG0_RST;
    end

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (wr_en && wr_addr == 8'(i)) begin
                bank_d[i*8 +: 8] = (i == 0) ? (wr_data & REG0_WMASK) : wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= rst_vec;
        else        bank_q <= bank_d;
    end

    always_comb begin
        rd_data = 8'd0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_addr == 8'(i)) rd_data = bank_q[i*8 +: 8];
        end
    end

    assign sw_ctl   = bank_q[BIT_SWCTL];
    assign oe0_o    = sw_ctl ? (bank_q[BIT_OE0] & bank_q[BIT_ALLEN]) : hw_oe0_i;
    assign oe1_o    = sw_ctl ? (bank_q[BIT_OE1] & bank_q[BIT_ALLEN]) : hw_oe1_i;
    assign all_en_o = sw_ctl ? bank_q[BIT_ALLEN] : 1'b1;
    assign bank_o   = bank_q;

    // R10
    oor_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && {1'b0, wr_addr} >= NREG9) |=> $stable(bank_q));

    // R7
    reserved_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 8'd0) |=> (bank_q[4:1] == 4'd0 &&
         bank_q[7:5] == $past(wr_data[7:5]) && bank_q[0] == $past(wr_data[0])));

    // R2
    last_reg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == LAST) |=> (bank_q[BW-1 -: 8] == $past(wr_data)));

endmodule

// File: rtl/clkcfg_smbus_target.sv
module clkcfg_smbus_target #(
    parameter logic [6:0] DEV_ADDR    = 7'b1101001,
    parameter int         NUM_REGS    = 4,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe_o,
    input  logic                  hw_oe0_i,
    input  logic                  hw_oe1_i,
    output logic                  oe0_o,
    output logic                  oe1_o,
    output logic                  all_en_o,
    output logic [NUM_REGS*8-1:0] cfg_o
);

    logic       sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic       wr_en;
    logic [7:0] wr_addr, wr_data, rd_addr, rd_data;

    clkcfg_line_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    clkcfg_bus_engine #(
        .DEV_ADDR (DEV_ADDR),
        .NUM_REGS (NUM_REGS)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .sda_oe    (sda_oe_o)
    );

    clkcfg_reg_bank #(
        .NUM_REGS (NUM_REGS)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .hw_oe0_i (hw_oe0_i),
        .hw_oe1_i (hw_oe1_i),
        .oe0_o    (oe0_o),
        .oe1_o    (oe1_o),
        .all_en_o (all_en_o),
        .bank_o   (cfg_o)
    );

endmodule

// File: tb/clkcfg_smbus_target_tb.sv
module clkcfg_smbus_target_tb;

    localparam int NREG = 4;
    localparam int Q    = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic scl_m = 1'b1, sda_m = 1'b1, hw0 = 1'b1, hw1 = 1'b0;
    logic sda_oe, oe0, oe1, all_en;
    logic [NREG*8-1:0] cfg;
    wire  sda_line = sda_m & ~sda_oe;

    clkcfg_smbus_target #(.NUM_REGS(NREG)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .hw_oe0_i(hw0), .hw_oe1_i(hw1),
        .oe0_o(oe0), .oe1_o(oe1), .all_en_o(all_en), .cfg_o(cfg)
    );

    int checks = 0, errors = 0;
    bit cmp_en = 1'b0;
    bit done = 1'b0;
    logic [7:0] mdl [NREG];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Per-clock reference comparison of the bank and the enable outputs (R2, R8, R9)
    always @(negedge clk) begin
        if (rst_n && cmp_en && !done) begin
            logic [NREG*8-1:0] ev;
            logic sw;
            for (int i = 0; i < NREG; i++) ev[i*8 +: 8] = mdl[i];
            sw = mdl[0][6];
            chk("R2 bank contents", 32'(cfg), 32'(ev));
            if (sw) chk("R9 enables under register control", {29'd0, oe0, oe1, all_en},
                        {29'd0, mdl[0][7] & mdl[0][5], mdl[0][0] & mdl[0][5], mdl[0][5]});
            else    chk("R8 enables under pin control", {29'd0, oe0, oe1, all_en},
                        {29'd0, hw0, hw1, 1'b1});
        end
    end

    task automatic wq(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic b_start;
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic b_stop;
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(Q);
    endtask

    task automatic clock_bit(input logic v, output logic s);
        sda_m = v;    wq(Q);
        scl_m = 1'b1; wq(Q);
        s = sda_line; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic nack);
        logic s;
        for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
        clock_bit(1'b1, nack);
    endtask

    task automatic recv_byte(input logic nack_it, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) clock_bit(1'b1, b[i]);
        clock_bit(nack_it, s);
        sda_m = 1'b1;
    endtask

    task automatic wr_block(input logic [7:0] off, input logic [7:0] n, input logic [7:0] data[$]);
        logic nk;
        b_start;
        send_byte(8'hD2, nk); chk("R1 write address ack", 32'(nk), 32'd0);
        send_byte(off, nk);   chk("R2 offset ack", 32'(nk), 32'd0);
        send_byte(n, nk);
        if (n == 8'd0) begin
            chk("R3 zero count nack", 32'(nk), 32'd1);
            foreach (data[k]) begin
                send_byte(data[k], nk);
                chk("R3 byte after zero count ignored", 32'(nk), 32'd1);
            end
        end else begin
            chk("R2 count ack", 32'(nk), 32'd0);
            foreach (data[k]) begin
                int idx;
                idx = int'(off) + k;
                cmp_en = 1'b0;
                send_byte(data[k], nk);
                if (k < int'(n)) begin
                    chk("R2 data ack", 32'(nk), 32'd0);
                    if (idx < NREG) mdl[idx] = (idx == 0) ? (data[k] & 8'hE1) : data[k];
                end else begin
                    chk("R4 excess data nack", 32'(nk), 32'd1);
                end
                cmp_en = 1'b1;
            end
        end
        b_stop;
        wq(4);
        chk("R12 SDA released after stop", 32'(sda_oe), 32'd0);
    endtask

    task automatic rd_block(input logic [7:0] off);
        logic nk;
        logic [7:0] b;
        int expcnt, nb;
        expcnt = (int'(off) < NREG) ? NREG - int'(off) : 0;
        nb = (expcnt == 0) ? 1 : expcnt;
        b_start;
        send_byte(8'hD2, nk); chk("R1 write address ack", 32'(nk), 32'd0);
        send_byte(off, nk);   chk("R5 offset ack", 32'(nk), 32'd0);
        b_start;
        send_byte(8'hD3, nk); chk("R1 read address ack", 32'(nk), 32'd0);
        recv_byte(1'b0, b);
        if (expcnt == 0) chk("R10 count past end", 32'(b), 32'd0);
        else             chk("R5 count byte", 32'(b), 32'(expcnt));
        for (int k = 0; k < nb; k++) begin
            logic [7:0] e;
            e = (int'(off) + k < NREG) ? mdl[int'(off) + k] : 8'h00;
            recv_byte(k == nb - 1, b);
            if (int'(off) + k < NREG) chk("R5 read data", 32'(b), 32'(e));
            else                      chk("R10 read past end", 32'(b), 32'(e));
        end
        wq(4);
        chk("R5 SDA released after NACK", 32'(sda_oe), 32'd0);
        b_stop;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic nk, s;
        mdl[0] = 8'hA1;
        for (int i = 1; i < NREG; i++) mdl[i] = 8'h00;
        wq(5);
        rst_n = 1'b1;
        wq(2);
        chk("R6 reset bank", 32'(cfg), 32'h000000A1);
        chk("R8 reset enables follow pins", {29'd0, oe0, oe1, all_en}, 32'b101);
        cmp_en = 1'b1;

        // R8: pin control follows the pins
        hw0 = 1'b0; hw1 = 1'b1; wq(3);
        chk("R8 pins toggled", {30'd0, oe0, oe1}, 32'b01);

        rd_block(8'd0);                      // R6, R5
        wr_block(8'd0, 8'd1, '{8'hFF});      // R7: reserved bits dropped
        rd_block(8'd0);
        wr_block(8'd0, 8'd1, '{8'h41});      // R9: global enable off
        chk("R9 global off", {29'd0, oe0, oe1, all_en}, 32'b000);
        wr_block(8'd0, 8'd1, '{8'h61});
        chk("R9 oe1 only", {29'd0, oe0, oe1, all_en}, 32'b011);
        wr_block(8'd1, 8'd3, '{8'h11, 8'h22, 8'h33});  // R2
        rd_block(8'd1);
        wr_block(8'd2, 8'd0, '{8'h77});      // R3
        wr_block(8'd3, 8'd1, '{8'h5A, 8'hC3}); // R4
        wr_block(8'd9, 8'd1, '{8'h55});      // R10
        rd_block(8'd9);
        wr_block(8'd3, 8'd2, '{8'h66, 8'h99}); // R10: second byte lands past end
        rd_block(8'd2);

        // R1: foreign address is ignored until the next start
        b_start;
        send_byte(8'hA4, nk); chk("R1 foreign address nack", 32'(nk), 32'd1);
        send_byte(8'h00, nk); chk("R1 ignored after foreign address", 32'(nk), 32'd1);
        send_byte(8'h01, nk); chk("R1 ignored after foreign address", 32'(nk), 32'd1);
        b_stop;

        // R11: stop in the middle of the offset byte
        b_start;
        send_byte(8'hD2, nk); chk("R11 address ack before abort", 32'(nk), 32'd0);
        for (int i = 0; i < 3; i++) clock_bit(1'b0, s);
        b_stop;
        wq(4);
        chk("R11 SDA released after mid-byte stop", 32'(sda_oe), 32'd0);
        scl_m = 1'b0; wq(Q);
        send_byte(8'hD2, nk); chk("R11 no ack without start", 32'(nk), 32'd1);
        send_byte(8'h00, nk); chk("R11 no ack without start", 32'(nk), 32'd1);
        sda_m = 1'b1; scl_m = 1'b1; wq(Q);
        rd_block(8'd0);

        // R8: back to pin control
        wr_block(8'd0, 8'd1, '{8'h21});
        hw0 = 1'b1; hw1 = 1'b1; wq(3);
        chk("R8 pin control restored", {29'd0, oe0, oe1, all_en}, 32'b111);

        done = 1'b1;
        cmp_en = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule